// File: doc/BRIEF.md
# UART Receive Buffer with Character Timeout

This block is the receive side storage of a 16550-class serial port. It takes whole bytes and break events from the receive shifter, holds them in a small first-in first-out buffer, and hands the oldest byte to the register read path. It keeps the line status bits that belong to reception: data available, overrun and break. It also runs an inactivity timer that flags bytes which have sat unread for too long.

Software controls the block through writes to the FIFO control register. Bit 0 turns buffering on or off, bit 1 empties the receive buffer, bit 2 asks for the transmit buffer to be emptied, and bits 7:6 pick the fill level at which a receive service request is raised. With buffering off the block acts as a single-byte holding register. The length of one character, in clock cycles, arrives on an input: one start bit, 5 to 8 data bits (line control bits 1:0 plus 5), an optional parity bit and the stop bits, each one bit period long. The bus decoder computes that value.

Top module: `uart_rx_buffer`

## Requirements
- R1: With buffering on, the buffer holds up to DEPTH (default 16) bytes and returns them in arrival order; `rx_level` gives the stored count and `rbr_data` shows the oldest byte.
- R2: A byte or break that arrives when the buffer is full is discarded, the stored bytes stay untouched, and `overrun_err` is set from the next cycle.
- R3: An arrival and an `rd_rbr` in the same cycle leave the count unchanged, also when full, and do not set `overrun_err`.
- R4: With buffering on, `rx_request` is high while the count is at least the fill level chosen by control bits 7:6 (00: 1, 01: 4, 10: 8, 11: 14 bytes); with buffering off it is high while a byte is held.
- R5: A control write whose bit 0 differs from the current mode switches the mode, empties the receive buffer and pulses `tx_flush` high for one cycle after the write.
- R6: A control write with bit 1 set empties the receive buffer, stops the timer and clears `timeout_pend`; bit 2 set pulses `tx_flush` one cycle after the write.
- R7: With buffering on, each arrival and each `rd_rbr` restarts a timer of 4 × `char_cycles` cycles; when it runs out `timeout_pend` is set, but only if the buffer is not empty.
- R8: `rd_rbr` clears `timeout_pend`; a read that leaves the buffer empty also clears `data_ready` and `break_det`.
- R9: A break event stores a 0x00 byte and sets `break_det` and `data_ready`.
- R10: `rd_lsr` clears `break_det` and `overrun_err` unless a new break or overrun happens in the same cycle.
- R11: With buffering off the block holds one byte; a new byte arriving while `data_ready` is set is discarded and sets `overrun_err`.
- R12: After reset the buffer is empty, buffering is off, the fill-level code is 00, and all status, request and pulse outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Received byte strobe from the shifter |
| rx_data | input | DW | Received byte |
| rx_break | input | 1 | Break condition detected by the shifter |
| rd_rbr | input | 1 | Read of the receive buffer register (pops one byte) |
| rd_lsr | input | 1 | Read of the line status register |
| fcr_wr | input | 1 | Write strobe for the FIFO control register |
| fcr_data | input | 8 | FIFO control write data |
| char_cycles | input | CW | Length of one character in clock cycles |
| rbr_data | output | DW | Oldest stored byte |
| rx_level | output | $clog2(DEPTH+1) | Number of stored bytes |
| data_ready | output | 1 | At least one byte is stored |
| overrun_err | output | 1 | A byte was lost to a full buffer |
| break_det | output | 1 | A break was received |
| timeout_pend | output | 1 | Character timeout is pending |
| rx_request | output | 1 | Receive service request (fill level reached) |
| fifo_on | output | 1 | Buffering mode is active |
| tx_flush | output | 1 | One-cycle request to empty the transmit buffer |

## Verification
The bench builds the block with its default 16-byte depth and an 8-bit character-time input driven to 3, so the timeout window is only 12 cycles and its exact expiry edge is checked on both sides. The small depth lets every one of the four fill-level codes be swept across every count from 1 to 16 with full data-order checks, and lets the full-buffer cases (discard, simultaneous arrival and read) be reached in a few dozen cycles.

// File: rtl/uart_rxf_pkg.sv
package uart_rxf_pkg;

    typedef enum logic [1:0] {
        TRIG_1  = 2'b00,
        TRIG_4  = 2'b01,
        TRIG_8  = 2'b10,
        TRIG_14 = 2'b11
    } trig_code_e;

    typedef struct packed {
        logic       en;
        logic       rx_clr;
        logic       tx_clr;
        trig_code_e trig;
    } fcr_cmd_t;

    // A mode change forces both buffers to be emptied.
    function automatic fcr_cmd_t decode_fcr(input logic [1:0] trig_bits,
                                            input logic [2:0] low_bits,
                                            input logic       cur_en);
        fcr_cmd_t c;
        logic     toggled;
        toggled  = low_bits[0] ^ cur_en;
        c.en     = low_bits[0];
        c.rx_clr = low_bits[1] | toggled;
        c.tx_clr = low_bits[2] | toggled;
        c.trig   = trig_code_e'(trig_bits);
        return c;
    endfunction

    function automatic int unsigned trig_bytes(input trig_code_e code);
        case (code)
            TRIG_1:  return 1;
            TRIG_4:  return 4;
            TRIG_8:  return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            push_req,
    input  logic            pop_req,
    input  logic [CNTW-1:0] cap,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    output logic [CNTW-1:0] count,
    output logic            dropped
);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          pop_ok, push_ok, full;

    assign full    = (count >= cap);
    assign pop_ok  = pop_req && (count != '0) && !clr;
    assign push_ok = push_req && !clr && (!full || pop_ok);
    assign dropped = push_req && !clr && !push_ok;
    assign rdata   = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R1: the count never exceeds the storage depth
    a_r1_count_bound: assert property (@(posedge clk) disable iff (rst)
        count <= CNTW'(DEPTH));

    // R3: arrival plus read on a non-empty buffer keeps the count
    a_r3_push_pop_hold: assert property (@(posedge clk) disable iff (rst)
        (push_req && pop_req && count != '0 && !clr) |=> (count == $past(count)));

endmodule

// File: rtl/rxf_timer.sv
module rxf_timer #(
    parameter int CW  = 16,
    localparam int TW = CW + 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cancel,
    input  logic          restart,
    input  logic          clr_pend,
    input  logic [CW-1:0] char_cycles,
    input  logic          nonempty,
    output logic          pend
);

    logic [TW-1:0] remain;
    logic          active;

    always_ff @(posedge clk) begin
        if (rst || cancel) begin
            remain <= '0;
            active <= 1'b0;
            pend   <= 1'b0;
        end else begin
            if (restart) begin
                remain <= {char_cycles, 2'b00};
                active <= 1'b1;
            end else if (active) begin
                if (remain <= TW'(1)) begin
                    active <= 1'b0;
                    if (nonempty) pend <= 1'b1;
                end else begin
                    remain <= remain - 1'b1;
                end
            end
            if (clr_pend) pend <= 1'b0;
        end
    end

    // R7: a timeout only rises while bytes are stored
    a_r7_pend_needs_data: assert property (@(posedge clk) disable iff (rst)
        $rose(pend) |-> nonempty);

    // R8: a buffer read leaves no pending timeout
    a_r8_read_clears_pend: assert property (@(posedge clk) disable iff (rst)
        clr_pend |=> !pend);

endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
    import uart_rxf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    parameter int CW    = 16,
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rx_valid,
    input  logic [DW-1:0]   rx_data,
    input  logic            rx_break,
    input  logic            rd_rbr,
    input  logic            rd_lsr,
    input  logic            fcr_wr,
    input  logic [7:0]      fcr_data,
    input  logic [CW-1:0]   char_cycles,
    output logic [DW-1:0]   rbr_data,
    output logic [CNTW-1:0] rx_level,
    output logic            data_ready,
    output logic            overrun_err,
    output logic            break_det,
    output logic            timeout_pend,
    output logic            rx_request,
    output logic            fifo_on,
    output logic            tx_flush
);

    fcr_cmd_t        cmd;
    trig_code_e      trig;
    logic            rx_clr, push_req, dropped, fcr_unused;
    logic [DW-1:0]   push_byte;
    logic [CNTW-1:0] cap;

    assign fcr_unused = ^fcr_data[5:3];
    assign cmd        = decode_fcr(fcr_data[7:6], fcr_data[2:0], fifo_on);
    assign rx_clr     = fcr_wr && cmd.rx_clr;
    assign push_req   = rx_valid || rx_break;
    assign push_byte  = rx_break ? '0 : rx_data;
    assign cap        = fifo_on ? CNTW'(DEPTH) : CNTW'(1);

    rxf_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk      (clk),
        .rst      (rst),
        .clr      (rx_clr),
        .push_req (push_req),
        .pop_req  (rd_rbr),
        .cap      (cap),
        .wdata    (push_byte),
        .rdata    (rbr_data),
        .count    (rx_level),
        .dropped  (dropped)
    );

    rxf_timer #(.CW(CW)) u_timer (
        .clk         (clk),
        .rst         (rst),
        .cancel      (rx_clr),
        .restart     (fifo_on && (push_req || rd_rbr)),
        .clr_pend    (rd_rbr),
        .char_cycles (char_cycles),
        .nonempty    (rx_level != '0),
        .pend        (timeout_pend)
    );

    assign data_ready = (rx_level != '0);
    assign rx_request = fifo_on ? (32'(rx_level) >= trig_bytes(trig))
                                : (rx_level != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            fifo_on  <= 1'b0;
            trig     <= TRIG_1;
            tx_flush <= 1'b0;
        end else begin
            tx_flush <= fcr_wr && cmd.tx_clr;
            if (fcr_wr) begin
                fifo_on <= cmd.en;
                trig    <= cmd.trig;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            overrun_err <= 1'b0;
            break_det   <= 1'b0;
        end else begin
            if (dropped)     overrun_err <= 1'b1;
            else if (rd_lsr) overrun_err <= 1'b0;

            if (rx_break)    break_det <= 1'b1;
            else if (rd_lsr) break_det <= 1'b0;
            else if (rd_rbr && !push_req && rx_level <= CNTW'(1))
                             break_det <= 1'b0;
        end
    end

    // R2: a lost arrival is reported as overrun
    a_r2_overrun_set: assert property (@(posedge clk) disable iff (rst)
        dropped |=> overrun_err);

    // R5: a mode change empties the buffer and requests a transmit flush
    a_r5_mode_flush: assert property (@(posedge clk) disable iff (rst)
        (fcr_wr && fcr_data[0] != fifo_on) |=> (rx_level == '0 && tx_flush));

    // R9: a break marks both break and data available
    a_r9_break_marks: assert property (@(posedge clk) disable iff (rst)
        (rx_break && !rx_clr) |=> (break_det && data_ready));

    // R10: a status read clears the sticky error bits
    a_r10_lsr_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_lsr && !rx_break && !dropped) |=> (!overrun_err && !break_det));

endmodule

// File: tb/tb_uart_rx_buffer.sv
module tb_uart_rx_buffer;

    localparam int DEPTH = 16;
    localparam int DW    = 8;
    localparam int CW    = 8;
    localparam int CNTW  = $clog2(DEPTH + 1);
    localparam int CHAR  = 3;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            rx_valid = 1'b0;
    logic [DW-1:0]   rx_data = '0;
    logic            rx_break = 1'b0;
    logic            rd_rbr = 1'b0;
    logic            rd_lsr = 1'b0;
    logic            fcr_wr = 1'b0;
    logic [7:0]      fcr_data = '0;
    logic [CW-1:0]   char_cycles = CW'(CHAR);
    logic [DW-1:0]   rbr_data;
    logic [CNTW-1:0] rx_level;
    logic            data_ready, overrun_err, break_det, timeout_pend;
    logic            rx_request, fifo_on, tx_flush;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    uart_rx_buffer #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) dut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_break(rx_break), .rd_rbr(rd_rbr), .rd_lsr(rd_lsr),
        .fcr_wr(fcr_wr), .fcr_data(fcr_data), .char_cycles(char_cycles),
        .rbr_data(rbr_data), .rx_level(rx_level), .data_ready(data_ready),
        .overrun_err(overrun_err), .break_det(break_det),
        .timeout_pend(timeout_pend), .rx_request(rx_request),
        .fifo_on(fifo_on), .tx_flush(tx_flush)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic push(input logic [7:0] b);
        rx_valid = 1'b1; rx_data = b;
        tick();
        rx_valid = 1'b0;
    endtask

    task automatic pop();
        rd_rbr = 1'b1;
        tick();
        rd_rbr = 1'b0;
    endtask

    task automatic read_lsr();
        rd_lsr = 1'b1;
        tick();
        rd_lsr = 1'b0;
    endtask

    task automatic send_break();
        rx_break = 1'b1;
        tick();
        rx_break = 1'b0;
    endtask

    task automatic write_fcr(input logic [7:0] v);
        fcr_wr = 1'b1; fcr_data = v;
        tick();
        fcr_wr = 1'b0;
    endtask

    function automatic logic [7:0] val(input int code, input int i);
        return 8'(code * 40 + i * 3 + 1);
    endfunction

    function automatic int lvl(input int code);
        return (code == 0) ? 1 : (code == 1) ? 4 : (code == 2) ? 8 : 14;
    endfunction

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        // R12 reset state
        check("R12 level", int'(rx_level), 0);
        check("R12 ready", int'(data_ready), 0);
        check("R12 overrun", int'(overrun_err), 0);
        check("R12 break", int'(break_det), 0);
        check("R12 timeout", int'(timeout_pend), 0);
        check("R12 fifo_on", int'(fifo_on), 0);
        check("R12 tx_flush", int'(tx_flush), 0);
        check("R12 request", int'(rx_request), 0);

        // R11 single-byte mode
        push(8'h11);
        check("R11 level", int'(rx_level), 1);
        check("R11 ready", int'(data_ready), 1);
        check("R4 request non-fifo", int'(rx_request), 1);
        push(8'h22);
        check("R11 overrun", int'(overrun_err), 1);
        check("R11 data kept", int'(rbr_data), 'h11);
        check("R11 level kept", int'(rx_level), 1);
        read_lsr();
        check("R10 overrun clear", int'(overrun_err), 0);
        pop();
        check("R8 ready clear", int'(data_ready), 0);

        // R5 enabling flushes
        push(8'h33);
        write_fcr(8'h01);
        check("R5 fifo_on", int'(fifo_on), 1);
        check("R5 level", int'(rx_level), 0);
        check("R5 tx_flush", int'(tx_flush), 1);
        tick();
        check("R5 tx_flush pulse", int'(tx_flush), 0);

        // R1 R4 R2 R3 sweep over trigger codes
        for (int code = 0; code < 4; code++) begin
            write_fcr(8'((code << 6) | 1));
            check("R5 no flush same mode", int'(tx_flush), 0);
            for (int i = 0; i < DEPTH; i++) begin
                push(val(code, i));
                check("R1 level", int'(rx_level), i + 1);
                check("R4 request", int'(rx_request), (i + 1 >= lvl(code)) ? 1 : 0);
            end
            if (code == 3) begin
                push(8'hEE);
                check("R2 overrun", int'(overrun_err), 1);
                check("R2 level", int'(rx_level), DEPTH);
                check("R2 head kept", int'(rbr_data), int'(val(code, 0)));
                read_lsr();
                check("R10 overrun clear", int'(overrun_err), 0);
                rx_valid = 1'b1; rx_data = 8'hAB; rd_rbr = 1'b1;
                tick();
                rx_valid = 1'b0; rd_rbr = 1'b0;
                check("R3 level", int'(rx_level), DEPTH);
                check("R3 no overrun", int'(overrun_err), 0);
                for (int i = 0; i < DEPTH; i++) begin
                    check("R3 order", int'(rbr_data),
                          (i < DEPTH - 1) ? int'(val(code, i + 1)) : 'hAB);
                    pop();
                end
            end else begin
                for (int i = 0; i < DEPTH; i++) begin
                    check("R1 order", int'(rbr_data), int'(val(code, i)));
                    pop();
                end
            end
            check("R1 empty", int'(rx_level), 0);
        end

        // R7 timeout timing
        repeat (4 * CHAR + 2) tick();
        check("R7 no pend empty", int'(timeout_pend), 0);
        push(8'h55);
        repeat (4 * CHAR - 1) tick();
        check("R7 not yet", int'(timeout_pend), 0);
        tick();
        check("R7 expired", int'(timeout_pend), 1);
        pop();
        check("R8 pend clear", int'(timeout_pend), 0);
        check("R8 ready clear", int'(data_ready), 0);
        repeat (4 * CHAR + 1) tick();
        check("R7 empty no pend", int'(timeout_pend), 0);

        // R6 receive clear and transmit flush
        push(8'h01);
        push(8'h02);
        repeat (4 * CHAR) tick();
        check("R7 pend", int'(timeout_pend), 1);
        write_fcr(8'h03);
        check("R6 level", int'(rx_level), 0);
        check("R6 pend", int'(timeout_pend), 0);
        check("R6 no tx flush", int'(tx_flush), 0);
        write_fcr(8'h05);
        check("R6 tx flush", int'(tx_flush), 1);
        check("R6 still on", int'(fifo_on), 1);

        // R9 break behaviour
        send_break();
        check("R9 level", int'(rx_level), 1);
        check("R9 break", int'(break_det), 1);
        check("R9 ready", int'(data_ready), 1);
        check("R9 zero byte", int'(rbr_data), 0);
        push(8'h66);
        pop();
        check("R8 break held", int'(break_det), 1);
        pop();
        check("R8 break clear", int'(break_det), 0);
        check("R8 empty", int'(data_ready), 0);
        send_break();
        read_lsr();
        check("R10 break clear", int'(break_det), 0);
        check("R10 level kept", int'(rx_level), 1);
        pop();

        // R5 disable
        push(8'h77);
        write_fcr(8'h00);
        check("R5 off", int'(fifo_on), 0);
        check("R5 level off", int'(rx_level), 0);
        check("R5 tx_flush off", int'(tx_flush), 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule